// File: doc/BRIEF.md
# Glitch-Free Card Clock Selector

This block generates the clock that drives a smart card contact. It chooses among eight clock sources derived from three input clocks: the main system clock, a dedicated card clock input and an external pin clock. The main and dedicated clocks are offered undivided, halved and quartered. The pin clock is offered undivided and halved. Each divided clock comes from a counter clocked by its own source, so it has a 50% duty cycle.

Software can stop the output and hold it at a chosen logic level. This puts an asynchronous card into power-down, or it lets software drive the contact directly by toggling the level bit. Every change of source, and every stop or restart, passes through a per-source enable handshake. The handshake releases the old source on its falling edge and admits the new source on its own falling edge, after the old one is confirmed off. The output therefore never shows a runt pulse. A status output tells software when the requested configuration is in effect. A sticky error output flags a switch into or out of the pin-clock group made while the output is running.

Top module: `cardClkSel`

## Requirements
- R1: With the output running, select code 0 drives the main clock undivided, code 6 drives it divided by 2, and code 7 drives it divided by 4.
- R2: With the output running, select codes 1, 2 and 3 drive the dedicated card clock input divided by 1, 2 and 4 respectively.
- R3: With the output running, select code 4 drives the external pin clock undivided and code 5 drives it divided by 2.
- R4: While `rstN` is low, `cardClk` is low and `cfgDone` is low. The registered select starts at code 0, so after reset with `stopReq` low the output runs from the undivided main clock.
- R5: When `stopReq` is 1, `cardClk` settles and then holds at the value of `stopLevel`: high for 1, low for 0.
- R6: Clearing `stopReq` restarts the output from the source named by `selCode`, at that source's frequency.
- R7: The output never shows a high or low pulse shorter than half a period of the fastest source involved. At most one source is gated onto the output at any time, and never while the stopped-high level is driven.
- R8: `swapErr` rises one `mainClk` cycle after a write that moves the select between the pin group (codes 4 and 5) and any other code while `stopReq` is 0 both before and during the write. The flag then stays set until the block is stopped, and it clears one cycle after the registered stop bit is 1.
- R9: After a write that changes the effective configuration, `cfgDone` is 0 at the second `mainClk` rising edge after the write. It returns to 1 once the new source or stopped level is in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mainClk | input | 1 | Main clock; also clocks the control registers |
| cardClkIn | input | 1 | Dedicated card clock source |
| pinClk | input | 1 | External pin clock source |
| rstN | input | 1 | Asynchronous active-low reset |
| selCode | input | 3 | Source select code, in the `mainClk` domain |
| stopReq | input | 1 | 1 stops the output at `stopLevel` |
| stopLevel | input | 1 | Level held on the output while stopped |
| cardClk | output | 1 | Clock driven to the card contact |
| cfgDone | output | 1 | 1 when the requested configuration is in effect |
| swapErr | output | 1 | Sticky flag for a cross-group switch made while running |

## Verification
The embedded properties watch, on every main clock edge, that no two source enables are on at once and that none is on while the high stop level is driven. They also watch that a cross-group switch while running raises the error flag, that a stop clears it, and that a configuration change drops the completion status. Output frequencies per select code, the held stop levels, restart behaviour and the absence of runt pulses across many switches are only visible in the bench scenarios. There, a monitor times every edge of the card clock, and period checks run once the status reports completion.

// File: rtl/cardClkPkg.sv
package cardClkPkg;
  localparam int LEG_COUNT = 8;
  localparam int SEL_W = $clog2(LEG_COUNT);

  // strobes from control into the datapath
  typedef struct packed {
    logic [LEG_COUNT-1:0] legReq;   // one-hot request for the running source
    logic                 holdHigh; // drive the stopped-high level
  } clkStrobes_t;

  // codes 4 and 5 belong to the external pin clock group
  function automatic logic isPinGroup(input logic [SEL_W-1:0] code);
    return (code == SEL_W'(4)) || (code == SEL_W'(5));
  endfunction
endpackage

// File: rtl/clkDivChain.sv
module clkDivChain #(
  parameter int STAGES = 2
) (
  input  logic          srcClk,
  input  logic          rstN,
  output logic [STAGES:0] taps
);
  logic [STAGES-1:0] divCnt;

  // binary counter: bit k toggles at srcClk / 2^(k+1) with 50% duty
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign taps = {divCnt, srcClk};
endmodule

// File: rtl/cardClkLeg.sv
module cardClkLeg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic legClk,
  input  logic rstN,
  input  logic legReq,
  input  logic blocked,
  output logic legEn,
  output logic gatedClk
);
  logic [SYNC_STAGES-1:0] syncQ;

  // enable changes only on the falling edge, while legClk is low
  always_ff @(negedge legClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], legReq & ~blocked};
  end

  assign legEn    = syncQ[SYNC_STAGES-1];
  assign gatedClk = legClk & legEn;
endmodule

// File: rtl/cardClkPath.sv
module cardClkPath
  import cardClkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 mainClk,
  input  logic                 cardClkIn,
  input  logic                 pinClk,
  input  logic                 rstN,
  input  clkStrobes_t          strobes,
  output logic                 cardClk,
  output logic [LEG_COUNT-1:0] legEnVec
);
  logic [2:0] mainTaps;
  logic [2:0] cardTaps;
  logic [1:0] pinTaps;
  logic [LEG_COUNT-1:0] legSrc;
  logic [LEG_COUNT-1:0] gatedVec;

  clkDivChain #(.STAGES(2)) u_mainDiv (.srcClk(mainClk),   .rstN(rstN), .taps(mainTaps));
  clkDivChain #(.STAGES(2)) u_cardDiv (.srcClk(cardClkIn), .rstN(rstN), .taps(cardTaps));
  clkDivChain #(.STAGES(1)) u_pinDiv  (.srcClk(pinClk),    .rstN(rstN), .taps(pinTaps));

  // source per select code; the code order is fixed by software
  assign legSrc[0] = mainTaps[0];
  assign legSrc[1] = cardTaps[0];
  assign legSrc[2] = cardTaps[1];
  assign legSrc[3] = cardTaps[2];
  assign legSrc[4] = pinTaps[0];
  assign legSrc[5] = pinTaps[1];
  assign legSrc[6] = mainTaps[1];
  assign legSrc[7] = mainTaps[2];

  for (genvar i = 0; i < LEG_COUNT; i++) begin : g_leg
    logic othersOn;
    assign othersOn = (|(legEnVec & ~(LEG_COUNT'(1) << i))) | strobes.holdHigh;
    cardClkLeg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
      .legClk  (legSrc[i]),
      .rstN    (rstN),
      .legReq  (strobes.legReq[i]),
      .blocked (othersOn),
      .legEn   (legEnVec[i]),
      .gatedClk(gatedVec[i])
    );
  end

  assign cardClk = (|gatedVec) | strobes.holdHigh;

  assert_single_leg_R7: assert property (@(posedge mainClk) disable iff (!rstN)
    $onehot0(legEnVec));

  assert_hold_exclusive_R7: assert property (@(posedge mainClk) disable iff (!rstN)
    strobes.holdHigh |-> (legEnVec == '0));
endmodule

// File: rtl/cardClkCtl.sv
module cardClkCtl
  import cardClkPkg::*;
(
  input  logic                 mainClk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     selCode,
  input  logic                 stopReq,
  input  logic                 stopLevel,
  input  logic [LEG_COUNT-1:0] legEnVec,
  output clkStrobes_t          strobes,
  output logic                 cfgDone,
  output logic                 swapErr
);
  logic [SEL_W-1:0]     selQ;
  logic                 stopQ;
  logic                 levelQ;
  logic [LEG_COUNT-1:0] enMeta;
  logic [LEG_COUNT-1:0] enSync;
  logic [LEG_COUNT-1:0] reqVec;
  logic                 wantHigh;
  logic                 crossing;

  assign reqVec   = stopQ ? '0 : (LEG_COUNT'(1) << selQ);
  assign wantHigh = stopQ & levelQ;
  assign crossing = !stopQ && !stopReq && (isPinGroup(selCode) != isPinGroup(selQ));

  always_ff @(posedge mainClk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= '0;
      stopQ   <= 1'b0;
      levelQ  <= 1'b0;
      enMeta  <= '0;
      enSync  <= '0;
      strobes <= '0;
      cfgDone <= 1'b0;
      swapErr <= 1'b0;
    end else begin
      selQ   <= selCode;
      stopQ  <= stopReq;
      levelQ <= stopLevel;
      enMeta <= legEnVec;
      enSync <= enMeta;
      strobes.legReq   <= reqVec;
      strobes.holdHigh <= wantHigh & (enSync == '0);
      cfgDone <= (enSync == reqVec) && (strobes.legReq == reqVec)
                 && (strobes.holdHigh == wantHigh);
      if (crossing)   swapErr <= 1'b1;
      else if (stopQ) swapErr <= 1'b0;
    end
  end

  assert_swap_flag_R8: assert property (@(posedge mainClk) disable iff (!rstN)
    crossing |=> swapErr);

  assert_swap_clear_R8: assert property (@(posedge mainClk) disable iff (!rstN)
    (stopQ && !crossing) |=> !swapErr);

  assert_done_drop_R9: assert property (@(posedge mainClk) disable iff (!rstN)
    (reqVec != $past(reqVec)) |=> !cfgDone);
endmodule

// File: rtl/cardClkSel.sv
module cardClkSel
  import cardClkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             mainClk,
  input  logic             cardClkIn,
  input  logic             pinClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selCode,
  input  logic             stopReq,
  input  logic             stopLevel,
  output logic             cardClk,
  output logic             cfgDone,
  output logic             swapErr
);
  clkStrobes_t          strobes;
  logic [LEG_COUNT-1:0] legEnVec;

  cardClkCtl u_ctl (
    .mainClk  (mainClk),
    .rstN     (rstN),
    .selCode  (selCode),
    .stopReq  (stopReq),
    .stopLevel(stopLevel),
    .legEnVec (legEnVec),
    .strobes  (strobes),
    .cfgDone  (cfgDone),
    .swapErr  (swapErr)
  );

  cardClkPath #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .mainClk  (mainClk),
    .cardClkIn(cardClkIn),
    .pinClk   (pinClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cardClk  (cardClk),
    .legEnVec (legEnVec)
  );
endmodule

// File: tb/cardClkSel_tb.sv
`timescale 1ns/1ps
module cardClkSel_tb;
  logic mainClk = 1'b0;
  logic cardClkIn = 1'b0;
  logic pinClk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] selCode = 3'd0;
  logic stopReq = 1'b0;
  logic stopLevel = 1'b0;
  logic cardClk, cfgDone, swapErr;

  int checkCount = 0;
  int failCount = 0;
  int glitchCount = 0;
  int riseCount = 0;
  bit monitorOn = 1'b0;
  realtime lastRise = 0, prevRise = 0, lastEdge = 0;

  always #2.5 mainClk = ~mainClk;   // 200 MHz, period 5 ns
  always #4   cardClkIn = ~cardClkIn; // period 8 ns
  always #6   pinClk = ~pinClk;       // period 12 ns

  cardClkSel u_dut (
    .mainClk(mainClk), .cardClkIn(cardClkIn), .pinClk(pinClk), .rstN(rstN),
    .selCode(selCode), .stopReq(stopReq), .stopLevel(stopLevel),
    .cardClk(cardClk), .cfgDone(cfgDone), .swapErr(swapErr)
  );

  always @(posedge cardClk) begin
    prevRise = lastRise;
    lastRise = $realtime;
    riseCount++;
  end

  // every pulse must last at least half the fastest source period (2.5 ns)
  always @(cardClk) begin
    if (monitorOn && ($realtime - lastEdge) < 2.4) glitchCount++;
    lastEdge = $realtime;
  end

  task automatic check(input bit ok, input string tag, input real act, input real exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  // write a configuration and wait for completion (R9)
  task automatic applyCfg(input logic [2:0] sel, input logic stp, input logic lvl,
                          input bit expectDrop);
    int waited = 0;
    @(negedge mainClk);
    selCode = sel; stopReq = stp; stopLevel = lvl;
    repeat (2) @(posedge mainClk);
    #1;
    if (expectDrop) check(cfgDone == 1'b0, "R9 status drop", cfgDone, 0);
    while (!cfgDone && waited < 400) begin
      @(posedge mainClk); #1;
      waited++;
    end
    check(cfgDone == 1'b1, "R9 status done", cfgDone, 1);
  endtask

  task automatic checkPeriod(input string tag, input real expPeriod);
    int startCount = riseCount;
    int guard = 0;
    while (riseCount < startCount + 4 && guard < 400) begin
      @(posedge mainClk); guard++;
    end
    check((lastRise - prevRise) > expPeriod - 0.01 && (lastRise - prevRise) < expPeriod + 0.01,
          tag, lastRise - prevRise, expPeriod);
  endtask

  task automatic checkHeld(input string tag, input logic lvl);
    bit held = 1'b1;
    for (int i = 0; i < 60; i++) begin
      #1.3;
      if (cardClk !== lvl) held = 1'b0;
    end
    check(held, tag, cardClk, lvl);
  endtask

  task automatic testReset();
    bit lowAll = 1'b1;
    for (int i = 0; i < 10; i++) begin
      #1.7;
      if (cardClk !== 1'b0 || cfgDone !== 1'b0) lowAll = 1'b0;
    end
    check(lowAll, "R4 outputs low in reset", cardClk, 0);
    @(negedge mainClk); rstN = 1'b1;
    monitorOn = 1'b1;
    applyCfg(3'd0, 1'b0, 1'b0, 1'b0);
    checkPeriod("R4 main clock after reset", 5.0);
    check(swapErr == 1'b0, "R8 flag clear after reset", swapErr, 0);
  endtask

  task automatic testMainAndCard();
    applyCfg(3'd6, 1'b0, 1'b0, 1'b1); checkPeriod("R1 code6 main/2", 10.0);
    applyCfg(3'd7, 1'b0, 1'b0, 1'b1); checkPeriod("R1 code7 main/4", 20.0);
    applyCfg(3'd1, 1'b0, 1'b0, 1'b1); checkPeriod("R2 code1 card/1", 8.0);
    applyCfg(3'd2, 1'b0, 1'b0, 1'b1); checkPeriod("R2 code2 card/2", 16.0);
    applyCfg(3'd3, 1'b0, 1'b0, 1'b1); checkPeriod("R2 code3 card/4", 32.0);
    applyCfg(3'd0, 1'b0, 1'b0, 1'b1); checkPeriod("R1 code0 main/1", 5.0);
  endtask

  task automatic testStopLevels();
    applyCfg(3'd0, 1'b1, 1'b0, 1'b1); checkHeld("R5 stopped low", 1'b0);
    applyCfg(3'd0, 1'b1, 1'b1, 1'b1); checkHeld("R5 stopped high", 1'b1);
    applyCfg(3'd2, 1'b0, 1'b0, 1'b1); checkPeriod("R6 restart card/2", 16.0);
    check(swapErr == 1'b0, "R8 no flag for in-group switches", swapErr, 0);
  endtask

  task automatic testPinGroup();
    applyCfg(3'd2, 1'b1, 1'b0, 1'b1);
    applyCfg(3'd4, 1'b1, 1'b0, 1'b0);
    applyCfg(3'd4, 1'b0, 1'b0, 1'b1); checkPeriod("R3 code4 pin/1", 12.0);
    applyCfg(3'd5, 1'b0, 1'b0, 1'b1); checkPeriod("R3 code5 pin/2", 24.0);
    check(swapErr == 1'b0, "R8 no flag for stopped group switch", swapErr, 0);
  endtask

  task automatic testSwapErr();
    @(negedge mainClk); selCode = 3'd0;
    @(posedge mainClk); #1;
    check(swapErr == 1'b1, "R8 flag after running swap", swapErr, 1);
    applyCfg(3'd0, 1'b0, 1'b0, 1'b1);
    checkPeriod("R7 main clock after running swap", 5.0);
    check(swapErr == 1'b1, "R8 flag sticky while running", swapErr, 1);
    applyCfg(3'd0, 1'b1, 1'b0, 1'b1);
    check(swapErr == 1'b0, "R8 flag cleared by stop", swapErr, 0);
    applyCfg(3'd7, 1'b0, 1'b0, 1'b1); checkPeriod("R6 restart main/4", 20.0);
  endtask

  initial begin
    #500us;
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    testReset();
    testMainAndCard();
    testStopLevels();
    testPinGroup();
    testSwapErr();
    check(glitchCount == 0, "R7 no runt pulses", glitchCount, 0);
    report();
  end
endmodule